// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block stands between a root port's configuration access requester and the downstream configuration transaction channel. It takes one configuration read or write at a time. Each request carries a bus, device, function, register offset, access size in bytes and write data. The block forwards the request downstream and then inspects the completion status. If a completion reports Configuration Request Retry Status (CRS), the block waits one microsecond and sends the identical request again. It keeps doing this until the request completes or a retry budget is used up. For reads it returns the data aligned to the access size.

A read of the Vendor ID dword can be answered without a retry when CRS software visibility is enabled. Requests to bus number 0 never leave the block. They are served by a small local register space that stands in for the root port's own configuration registers.

Top module: `cfg_retry_engine`

## Requirements
- R1: Only one request is in flight at a time. `req_ready_o` is high only when no transaction is open, and it stays low from acceptance until the response handshake completes.
- R2: A request to a non-zero bus is presented on the `dn_*` channel with the fields captured at acceptance. `dn_valid_o` and those fields are held until `dn_ready_i` is sampled high.
- R3: A completion with status 0 ends the transaction. A read returns the completion dword, aligned as in R10, with `rsp_err_o` low. A write returns data 0 with `rsp_err_o` low.
- R4: A completion with status 2 (CRS), when software visibility is off, causes the same request to be presented again. Exactly `CYC_PER_US` cycles with `dn_valid_o` low pass between the completion cycle and the reissue.
- R5: When `crs_sv_en_i` is high and a read whose offset lies in dword 0 (offset bits 11:2 zero) completes with CRS, the block does not reissue. It returns the dword 0xFFFF0001, aligned as in R10, with `rsp_err_o` low.
- R6: When `crs_sv_en_i` is high, writes and reads of any other dword that complete with CRS are still reissued as in R4.
- R7: A request is sent at most `MAX_RETRIES`+1 times. If the last of these also completes with CRS, a read returns the all-ones dword, aligned, with `rsp_err_o` low.
- R8: A write that runs out of retries responds with `rsp_err_o` high and data 0.
- R9: Any completion status other than 0 or 2 ends the transaction with no reissue and with `rsp_err_o` high. A read returns the all-ones dword, aligned. A write returns 0.
- R10: Read data is the dword shifted right by 8 times offset bits 1:0, then masked to 8 bits when `req_size_i` is 1, to 16 bits when it is 2, and left whole when it is 4.
- R11: Requests to bus 0 produce no `dn_valid_o` and are served by the local space. A write updates only the byte lanes selected by size and offset bits 1:0, with the data shifted into those lanes. A read returns the stored dword, aligned. Dword indices at or above `LOCAL_DWORDS` read as 0 and ignore writes. All local dwords reset to 0.
- R12: Once `rsp_valid_o` is high, it and the response data stay constant until `rsp_ready_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crs_sv_en_i | input | 1 | CRS software visibility enable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = configuration write |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 3 | Function number |
| req_off_i | input | 12 | Register byte offset |
| req_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rdata_o | output | 32 | Aligned read data |
| rsp_err_o | output | 1 | Transaction failed |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request taken |
| dn_write_o | output | 1 | Downstream write flag |
| dn_bus_o | output | 8 | Downstream bus |
| dn_dev_o | output | 5 | Downstream device |
| dn_func_o | output | 3 | Downstream function |
| dn_off_o | output | 12 | Downstream offset |
| dn_size_o | output | 3 | Downstream size |
| dn_wdata_o | output | 32 | Downstream write data |
| cpl_valid_i | input | 1 | Completion valid |
| cpl_status_i | input | 3 | Completion status (0 success, 2 CRS) |
| cpl_data_i | input | 32 | Completion dword |

## Verification
The embedded assertions watch the channel rules on every cycle. They check that only one transaction is open, that downstream and response payloads are held while stalled, and that no reissue ever changes the request fields. They also check that bus 0 never reaches the downstream channel, that the retry counter stays within budget, and that a software-visible Vendor ID read answers at once. The bench's scenarios are needed for the values themselves: the one-microsecond spacing, the number of sends before a timeout, the synthesized 0xFFFF0001 and all-ones data, the error flag on each failure path, sub-dword extraction and byte-lane merging in the local space.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = OFF_W - 2;

  localparam logic [2:0] CPL_OK  = 3'd0;
  localparam logic [2:0] CPL_CRS = 3'd2;

  localparam logic [DATA_W-1:0] VID_RETRY_WORD = 32'hFFFF_0001;
  localparam logic [DATA_W-1:0] ALL_ONES       = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCAL,
    ST_ISSUE,
    ST_WAITC,
    ST_DELAY,
    ST_RESP
  } eng_state_e;

  typedef struct packed {
    logic              write;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [OFF_W-1:0]  off;
    logic [SIZE_W-1:0] size;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/cfg_us_timer.sv
module cfg_us_timer #(
  parameter int unsigned CYC_PER_US = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // a fresh wait never ends on its first cycle when the period spans several cycles
  assert_fresh_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CYC_PER_US > 1) && run_i && !$past(run_i) |-> !expire_o);
endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
  import cfg_retry_pkg::*;
(
  input  logic [DATA_W-1:0] dword_i,
  input  logic [1:0]        lane_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [DATA_W-1:0] mask;
  logic [3:0]        be_base;
  logic [4:0]        sh;

  always_comb begin
    unique case (size_i)
      3'd1:    begin mask = 32'h0000_00FF; be_base = 4'b0001; end
      3'd2:    begin mask = 32'h0000_FFFF; be_base = 4'b0011; end
      default: begin mask = 32'hFFFF_FFFF; be_base = 4'b1111; end
    endcase
  end

  assign sh      = {lane_i, 3'b000};
  assign rdata_o = (dword_i >> sh) & mask;
  assign be_o    = be_base << lane_i;
  assign wdata_o = wdata_i << sh;
endmodule

// File: rtl/cfg_local_space.sv
module cfg_local_space
  import cfg_retry_pkg::*;
#(
  parameter int unsigned LOCAL_DWORDS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [LOCAL_DWORDS];

  for (genvar g = 0; g < LOCAL_DWORDS; g++) begin : g_dw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (wr_en_i && idx_i == IDX_W'(g)) begin
        for (int b = 0; b < 4; b++) begin
          if (be_i[b]) mem_q[g][8*b +: 8] <= wdata_i[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < LOCAL_DWORDS; i++) begin
      if (idx_i == IDX_W'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfg_retry_pkg::*;
#(
  parameter int unsigned CYC_PER_US   = 50,
  parameter int unsigned MAX_RETRIES  = 500000,
  parameter int unsigned LOCAL_DWORDS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        crs_sv_en_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_bus_i,
  input  logic [4:0]  req_dev_i,
  input  logic [2:0]  req_func_i,
  input  logic [11:0] req_off_i,
  input  logic [2:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_err_o,
  output logic        dn_valid_o,
  input  logic        dn_ready_i,
  output logic        dn_write_o,
  output logic [7:0]  dn_bus_o,
  output logic [4:0]  dn_dev_o,
  output logic [2:0]  dn_func_o,
  output logic [11:0] dn_off_o,
  output logic [2:0]  dn_size_o,
  output logic [31:0] dn_wdata_o,
  input  logic        cpl_valid_i,
  input  logic [2:0]  cpl_status_i,
  input  logic [31:0] cpl_data_i
);
  localparam int unsigned RW = (MAX_RETRIES > 0) ? $clog2(MAX_RETRIES + 1) : 1;
  localparam logic [RW-1:0] RETRY_LAST = RW'(MAX_RETRIES);

  eng_state_e        state_q;
  cfg_req_t          req_q;
  logic [RW-1:0]     rcnt_q;
  logic [DATA_W-1:0] raw_q;
  logic              err_q;

  logic              tmr_expire;
  logic [DATA_W-1:0] loc_rdata, wr_shifted;
  logic [3:0]        wr_be;
  logic              vid_hit;

  cfg_us_timer #(.CYC_PER_US(CYC_PER_US)) i_timer (
    .clk_i, .rst_ni,
    .run_i   (state_q == ST_DELAY),
    .expire_o(tmr_expire)
  );

  cfg_lane_align i_align (
    .dword_i(raw_q),
    .lane_i (req_q.off[1:0]),
    .size_i (req_q.size),
    .wdata_i(req_q.wdata),
    .rdata_o(rsp_rdata_o),
    .be_o   (wr_be),
    .wdata_o(wr_shifted)
  );

  cfg_local_space #(.LOCAL_DWORDS(LOCAL_DWORDS)) i_local (
    .clk_i, .rst_ni,
    .wr_en_i(state_q == ST_LOCAL && req_q.write),
    .idx_i  (req_q.off[OFF_W-1:2]),
    .be_i   (wr_be),
    .wdata_i(wr_shifted),
    .rdata_o(loc_rdata)
  );

  assign vid_hit = crs_sv_en_i && !req_q.write && (req_q.off[OFF_W-1:2] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      rcnt_q  <= '0;
      raw_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          req_q   <= '{write: req_write_i, bus: req_bus_i, dev: req_dev_i, func: req_func_i,
                       off: req_off_i, size: req_size_i, wdata: req_wdata_i};
          rcnt_q  <= '0;
          raw_q   <= '0;
          err_q   <= 1'b0;
          state_q <= (req_bus_i == '0) ? ST_LOCAL : ST_ISSUE;
        end
        ST_LOCAL: begin
          raw_q   <= req_q.write ? '0 : loc_rdata;
          state_q <= ST_RESP;
        end
        ST_ISSUE: if (dn_ready_i) state_q <= ST_WAITC;
        ST_WAITC: if (cpl_valid_i) begin
          if (cpl_status_i == CPL_OK) begin
            raw_q   <= req_q.write ? '0 : cpl_data_i;
            state_q <= ST_RESP;
          end else if (cpl_status_i == CPL_CRS) begin
            if (vid_hit) begin
              raw_q   <= VID_RETRY_WORD;
              state_q <= ST_RESP;
            end else if (rcnt_q == RETRY_LAST) begin
              raw_q   <= req_q.write ? '0 : ALL_ONES;
              err_q   <= req_q.write;
              state_q <= ST_RESP;
            end else begin
              rcnt_q  <= rcnt_q + 1'b1;
              state_q <= ST_DELAY;
            end
          end else begin
            raw_q   <= req_q.write ? '0 : ALL_ONES;
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end
        end
        ST_DELAY: if (tmr_expire) state_q <= ST_ISSUE;
        ST_RESP:  if (rsp_ready_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_err_o   = err_q;
  assign dn_valid_o  = (state_q == ST_ISSUE);
  assign dn_write_o  = req_q.write;
  assign dn_bus_o    = req_q.bus;
  assign dn_dev_o    = req_q.dev;
  assign dn_func_o   = req_q.func;
  assign dn_off_o    = req_q.off;
  assign dn_size_o   = req_q.size;
  assign dn_wdata_o  = req_q.wdata;

  assert_single_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !dn_valid_o && !rsp_valid_o);

  assert_dn_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o &&
      $stable({dn_write_o, dn_bus_o, dn_dev_o, dn_func_o, dn_off_o, dn_size_o, dn_wdata_o}));

  assert_same_reissue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && $past(!req_ready_o) |->
      $stable({dn_write_o, dn_bus_o, dn_dev_o, dn_func_o, dn_off_o, dn_size_o, dn_wdata_o}));

  assert_vid_direct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAITC) && cpl_valid_i && cpl_status_i == CPL_CRS && vid_hit
      |=> rsp_valid_o && !rsp_err_o);

  assert_budget_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt_q <= RETRY_LAST);

  assert_bad_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAITC) && cpl_valid_i && cpl_status_i != CPL_OK && cpl_status_i != CPL_CRS
      |=> rsp_valid_o && rsp_err_o);

  assert_no_dn_bus0_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> dn_bus_o != '0);

  assert_rsp_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o));
endmodule

// File: tb/test_cfg_retry_engine.sv
module test_cfg_retry_engine;
  localparam int CYC = 4;
  localparam int MAXR = 3;
  localparam int LDW = 4;

  logic        clk = 0, rst_n = 0;
  logic        sv_en = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [7:0]  req_bus = 0;
  logic [4:0]  req_dev = 0;
  logic [2:0]  req_func = 0, req_size = 4;
  logic [11:0] req_off = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_err;
  logic [31:0] rsp_rdata;
  logic        dn_valid, dn_ready = 1, dn_write;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_func, dn_size;
  logic [11:0] dn_off;
  logic [31:0] dn_wdata;
  logic        cpl_valid = 0;
  logic [2:0]  cpl_status = 0;
  logic [31:0] cpl_data = 32'hA1B2_C3D4;

  int checks = 0, errors = 0;
  int cyc = 0, issues = 0, pend = 0, crs_cyc = 0;
  bit await_reissue = 0;
  int stat_q[$];

  // reference state
  bit          busy = 0, rsp_hold = 0;
  logic [31:0] prev_rdata;
  logic        prev_err;
  logic        e_write;
  logic [7:0]  e_bus;
  logic [4:0]  e_dev;
  logic [2:0]  e_func, e_size;
  logic [11:0] e_off;
  logic [31:0] e_wdata;

  always #10 clk = ~clk;

  cfg_retry_engine #(.CYC_PER_US(CYC), .MAX_RETRIES(MAXR), .LOCAL_DWORDS(LDW)) i_cfg_retry_engine (
    .clk_i(clk), .rst_ni(rst_n), .crs_sv_en_i(sv_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bus_i(req_bus), .req_dev_i(req_dev), .req_func_i(req_func), .req_off_i(req_off),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_write_o(dn_write), .dn_bus_o(dn_bus),
    .dn_dev_o(dn_dev), .dn_func_o(dn_func), .dn_off_o(dn_off), .dn_size_o(dn_size),
    .dn_wdata_o(dn_wdata),
    .cpl_valid_i(cpl_valid), .cpl_status_i(cpl_status), .cpl_data_i(cpl_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock reference comparison, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    chk(req_ready == !busy, "R1 ready vs open txn", 32'(req_ready), 32'(!busy));
    if (dn_valid) begin
      chk(busy, "R1 dn while idle", 32'(busy), 32'd1);
      chk({dn_write, dn_bus, dn_dev, dn_func, dn_off, dn_size} ==
          {e_write, e_bus, e_dev, e_func, e_off, e_size} && dn_wdata == e_wdata,
          "R2 dn fields", {20'd0, dn_off}, {20'd0, e_off});
      chk(e_bus != 0, "R11 bus0 sent downstream", 32'(dn_bus), 32'd1);
      if (await_reissue) begin
        chk(cyc - crs_cyc - 1 == CYC, "R4 reissue spacing", 32'(cyc - crs_cyc - 1), 32'(CYC));
        await_reissue = 0;
      end
      if (dn_ready) begin
        issues++;
        pend = 2;
      end
    end
    if (rsp_hold)
      chk(rsp_valid && rsp_rdata == prev_rdata && rsp_err == prev_err, "R12 rsp hold",
          rsp_rdata, prev_rdata);
    if (rsp_valid) await_reissue = 0;
    if (req_valid && req_ready) begin
      busy = 1;
      {e_write, e_bus, e_dev, e_func, e_off, e_size, e_wdata} =
        {req_write, req_bus, req_dev, req_func, req_off, req_size, req_wdata};
    end
    if (rsp_valid && rsp_ready) busy = 0;
    rsp_hold   = rsp_valid && !rsp_ready;
    prev_rdata = rsp_rdata;
    prev_err   = rsp_err;
  end

  // downstream completer
  always @(posedge clk) begin
    #1;
    cpl_valid = 0;
    dn_ready  = (cyc % 3) != 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cpl_valid  = 1;
        cpl_status = (stat_q.size() > 0) ? 3'(stat_q.pop_front()) : 3'd0;
        if (cpl_status == 3'd2) begin
          crs_cyc = cyc;
          await_reissue = 1;
        end
      end
    end
  end

  task automatic txn(input bit wr, input logic [7:0] bus, input logic [11:0] off,
                     input logic [2:0] sz, input logic [31:0] wd, input int exp_iss,
                     input logic [31:0] exp_d, input bit exp_e, input string tag);
    issues = 0;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_bus = bus; req_dev = 5'd3; req_func = 3'd1;
    req_off = off; req_size = sz; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    do @(negedge clk); while (!rsp_valid);
    chk(rsp_rdata == exp_d, {tag, " data"}, rsp_rdata, exp_d);
    chk(rsp_err == exp_e, {tag, " err"}, 32'(rsp_err), 32'(exp_e));
    chk(issues == exp_iss, {tag, " sends"}, 32'(issues), 32'(exp_iss));
    @(posedge clk); #1;
    @(posedge clk); #1;
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && !dn_valid && !rsp_valid, "R1 reset state", {req_ready, dn_valid, rsp_valid}, 32'h4);
    rst_n = 1;

    // R3 / R10 plain success
    stat_q.push_back(0); txn(0, 8'd5, 12'h010, 3'd4, 0, 1, 32'hA1B2C3D4, 0, "R3 read dword");
    stat_q.push_back(0); txn(0, 8'd5, 12'h011, 3'd1, 0, 1, 32'h000000C3, 0, "R10 byte1");
    stat_q.push_back(0); txn(0, 8'd5, 12'h012, 3'd2, 0, 1, 32'h0000A1B2, 0, "R10 half2");
    stat_q.push_back(0); txn(0, 8'd5, 12'h013, 3'd2, 0, 1, 32'h000000A1, 0, "R10 half3");
    stat_q.push_back(0); txn(1, 8'd5, 12'h014, 3'd4, 32'h5566_7788, 1, 0, 0, "R3 write");

    // R4 retries with visibility off
    stat_q.push_back(2); stat_q.push_back(2); stat_q.push_back(0);
    txn(0, 8'd7, 12'h010, 3'd4, 0, 3, 32'hA1B2C3D4, 0, "R4 two crs");
    stat_q.push_back(2); stat_q.push_back(0);
    txn(0, 8'd7, 12'h000, 3'd4, 0, 2, 32'hA1B2C3D4, 0, "R4 vid without sv");

    // R5 / R6 visibility on
    sv_en = 1;
    stat_q.push_back(2); txn(0, 8'd2, 12'h000, 3'd4, 0, 1, 32'hFFFF0001, 0, "R5 vid dword");
    stat_q.push_back(2); txn(0, 8'd2, 12'h000, 3'd2, 0, 1, 32'h00000001, 0, "R5 vid half");
    stat_q.push_back(2); txn(0, 8'd2, 12'h002, 3'd2, 0, 1, 32'h0000FFFF, 0, "R5 did half");
    stat_q.push_back(2); stat_q.push_back(0);
    txn(1, 8'd2, 12'h000, 3'd4, 32'h1, 2, 0, 0, "R6 write retried");
    stat_q.push_back(2); stat_q.push_back(2); stat_q.push_back(0);
    txn(0, 8'd2, 12'h008, 3'd4, 0, 3, 32'hA1B2C3D4, 0, "R6 other offset");
    sv_en = 0;

    // R7 / R8 budget
    for (int i = 0; i <= MAXR; i++) stat_q.push_back(2);
    txn(0, 8'd9, 12'h020, 3'd4, 0, MAXR + 1, 32'hFFFFFFFF, 0, "R7 read timeout");
    for (int i = 0; i <= MAXR; i++) stat_q.push_back(2);
    txn(0, 8'd9, 12'h021, 3'd1, 0, MAXR + 1, 32'h000000FF, 0, "R7 byte timeout");
    for (int i = 0; i <= MAXR; i++) stat_q.push_back(2);
    txn(1, 8'd9, 12'h020, 3'd4, 32'h77, MAXR + 1, 0, 1, "R8 write timeout");

    // R9 other statuses
    stat_q.push_back(1); txn(0, 8'd4, 12'h030, 3'd4, 0, 1, 32'hFFFFFFFF, 1, "R9 status1 read");
    stat_q.push_back(4); txn(1, 8'd4, 12'h030, 3'd4, 32'h9, 1, 0, 1, "R9 status4 write");
    stat_q.push_back(2); stat_q.push_back(4);
    txn(0, 8'd4, 12'h031, 3'd2, 0, 2, 32'h0000FFFF, 1, "R9 crs then abort");

    // R11 local space on bus 0
    txn(0, 8'd0, 12'h004, 3'd4, 0, 0, 32'h0, 0, "R11 reset value");
    txn(1, 8'd0, 12'h004, 3'd4, 32'h1122_3344, 0, 0, 0, "R11 write dword");
    txn(0, 8'd0, 12'h004, 3'd4, 0, 0, 32'h11223344, 0, "R11 read dword");
    txn(1, 8'd0, 12'h005, 3'd1, 32'h0000_00AA, 0, 0, 0, "R11 write byte");
    txn(1, 8'd0, 12'h006, 3'd2, 32'h0000_BEEF, 0, 0, 0, "R11 write half");
    txn(0, 8'd0, 12'h004, 3'd4, 0, 0, 32'hBEEFAA44, 0, "R11 lanes merged");
    txn(0, 8'd0, 12'h007, 3'd1, 0, 0, 32'h000000BE, 0, "R11 byte read");
    txn(1, 8'd0, 12'h040, 3'd4, 32'hDEAD_BEEF, 0, 0, 0, "R11 write out of range");
    txn(0, 8'd0, 12'h040, 3'd4, 0, 0, 32'h0, 0, "R11 out of range reads 0");

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule